// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers twenty-two maskable interrupt sources and one non-maskable request and presents a single winning request to a CPU core. Each maskable source owns a pending flag and a 3-bit level. The sources are packed two to a byte-wide configuration register on a small register bus. Nineteen sources are internal peripheral events that arrive as set pulses. Three are external pins with their own detection rules.

The controller compares every eligible pending source against the CPU's current 3-bit mask. It drives a request, the vector offset of the winner and the level that the core should load into its mask field when it accepts the request. The core answers with a one-cycle acknowledge, and the controller then drops the pending flag of the source it was presenting. Stacking the program counter and status word, and fetching the vector, stay in the core.

Top module: `irq_ctrl`

## Requirements
- R1: After reset no request is driven and every configuration register reads 0x00.
- R2: Register r (0 to 10) holds source 2r+1 in its upper nibble and source 2r in its lower nibble. In each nibble the top bit is the pending flag and the lower three bits are the level. A write updates only the level fields and leaves both pending bits unchanged. A read returns the register one cycle after the write.
- R3: Source k has vector offset 0x28+4k for k below 5 and 0x2C+4k from k=5 upward, so offset 0x3C is never produced. Source 21 uses 0x80 and the non-maskable request uses 0x20.
- R4: A pending source is eligible only when its level is nonzero and is not below cpu_mask_i. A pending source with level 0 never raises a request.
- R5: Among eligible sources the highest level wins. On equal levels the lowest source index (lowest offset) wins.
- R6: irq_lvl_o carries the winner's level, or 7 when the non-maskable request is presented.
- R7: An irq_ack_i pulse clears the flag of the presented source on the next clock, and the next winner appears at once. A set pulse for that same source in the acknowledge cycle wins, and the flag stays pending.
- R8: Source 0 (pin int0_i) is ignored while int0_en_i is low. With int0_edge_i high, a rising edge sets its flag. With int0_edge_i low, its flag follows the pin level one clock later.
- R9: Sources 1 and 2 (pins int4_i, int5_i) set their flags on a rising edge, and only while int4_port_i or int5_port_i respectively is low.
- R10: A rising edge on nmi_i latches a request that is presented ahead of every maskable source with irq_nmi_o high, whatever the mask. An acknowledge clears it. A level held high does not latch it again.
- R11: Source k, for k from 3 to 21, becomes pending on a clock where src_set_i[k-3] is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| src_set_i | input | 19 | Set pulses for sources 3 to 21 |
| int0_i | input | 1 | External pin for source 0 |
| int0_en_i | input | 1 | Enables source 0 detection |
| int0_edge_i | input | 1 | 1: rising edge, 0: level for source 0 |
| int4_i | input | 1 | External pin for source 1 |
| int4_port_i | input | 1 | 1: pin used as a port, detection off |
| int5_i | input | 1 | External pin for source 2 |
| int5_port_i | input | 1 | 1: pin used as a port, detection off |
| nmi_i | input | 1 | Non-maskable request pin |
| cpu_mask_i | input | 3 | Current CPU mask level |
| irq_ack_i | input | 1 | One-cycle acceptance pulse |
| irq_req_o | output | 1 | Request to the core |
| irq_nmi_o | output | 1 | Presented request is non-maskable |
| irq_vec_o | output | 8 | Vector offset of the presented request |
| irq_lvl_o | output | 3 | New mask level on acceptance |

## Verification
Every flag change is due exactly one clock edge after the stimulus. This covers a set pulse, a pin edge, a pin level in level mode, an acknowledge and a register write. The request, vector and level outputs follow from the registered flags with no further delay. A change of cpu_mask_i shows on the outputs in the same cycle. The bench drives every input a short time after a rising edge and samples after one more rising edge plus settling time. Mask-only changes are sampled after settling, before the next edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC    = 22;
  localparam int LVL_W    = 3;
  localparam int N_PIN    = 3;
  localparam int HOLE_IDX = 5;
  localparam int VEC_BASE = 'h28;
  localparam int VEC_STEP = 4;
  localparam int NMI_VEC  = 'h20;

  // offset of maskable source k, skipping the reserved slot
  function automatic logic [7:0] vec_of(input int k);
    return 8'(VEC_BASE + VEC_STEP * (k + ((k >= HOLE_IDX) ? 1 : 0)));
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic en_i,
  input  logic edge_i,
  output logic set_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;

  assign set_o = en_i & edge_i & pin_i & ~prev_q;
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N_SRC  = 22,
  parameter int LVL_W  = 3,
  parameter int ADDR_W = 4,
  localparam int FW    = LVL_W + 1,
  localparam int DW    = 2 * FW,
  localparam int REG_N = N_SRC / 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [DW-1:0]               rdata_o,
  input  logic [N_SRC-1:0]            set_i,
  input  logic [N_SRC-1:0]            clr_i,
  input  logic                        lvl_mode_i,
  input  logic                        lvl_val_i,
  output logic [N_SRC-1:0]            pend_o,
  output logic [N_SRC-1:0][LVL_W-1:0] lvl_o
);
  logic [N_SRC-1:0]            pend_q;
  logic [N_SRC-1:0][LVL_W-1:0] lvl_q;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    localparam int R   = k / 2;
    localparam int OFS = (k % 2) * FW;
    logic hit;
    logic follow;
    assign hit    = we_i && (addr_i == ADDR_W'(R));
    assign follow = (k == 0) && lvl_mode_i;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        lvl_q[k]  <= '0;
        pend_q[k] <= 1'b0;
      end else begin
        if (hit) lvl_q[k] <= wdata_i[OFS +: LVL_W];
        if (follow) pend_q[k] <= lvl_val_i;
        else        pend_q[k] <= set_i[k] | (pend_q[k] & ~clr_i[k]);
      end

    a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k] && !follow) |=> !pend_q[k]);
    a_r2_wr_keeps_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && !set_i[k] && !clr_i[k] && !follow) |=> (pend_q[k] == $past(pend_q[k])));
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < REG_N; r++)
      if (addr_i == ADDR_W'(r))
        rdata_o = {pend_q[2*r+1], lvl_q[2*r+1], pend_q[2*r], lvl_q[2*r]};
  end

  assign pend_o = pend_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC  = 22,
  parameter int LVL_W  = 3,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]            pend_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]            mask_i,
  output logic                        vld_o,
  output logic [IDX_W-1:0]            idx_o,
  output logic [LVL_W-1:0]            lvl_o
);
  // strict compare keeps the lowest index on equal levels
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int k = 0; k < N_SRC; k++)
      if (pend_i[k] && lvl_i[k] != '0 && lvl_i[k] >= mask_i &&
          (!vld_o || lvl_i[k] > lvl_o)) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(k);
        lvl_o = lvl_i[k];
      end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC_P  = N_SRC,
  parameter int LVL_W_P  = LVL_W,
  localparam int N_PER   = N_SRC_P - N_PIN,
  localparam int REG_N   = N_SRC_P / 2,
  localparam int ADDR_W  = $clog2(REG_N),
  localparam int DW      = 2 * (LVL_W_P + 1),
  localparam int IDX_W   = $clog2(N_SRC_P)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic [N_PER-1:0]   src_set_i,
  input  logic               int0_i,
  input  logic               int0_en_i,
  input  logic               int0_edge_i,
  input  logic               int4_i,
  input  logic               int4_port_i,
  input  logic               int5_i,
  input  logic               int5_port_i,
  input  logic               nmi_i,
  input  logic [LVL_W_P-1:0] cpu_mask_i,
  input  logic               irq_ack_i,
  output logic               irq_req_o,
  output logic               irq_nmi_o,
  output logic [7:0]         irq_vec_o,
  output logic [LVL_W_P-1:0] irq_lvl_o
);
  logic [N_PIN-1:0] pin, pin_en, pin_edge, pin_set;
  logic [N_SRC_P-1:0] set, clr, pend;
  logic [N_SRC_P-1:0][LVL_W_P-1:0] lvl;
  logic win_vld;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W_P-1:0] win_lvl;
  logic nmi_rise, nmi_q;

  assign pin      = {int5_i, int4_i, int0_i};
  assign pin_en   = {~int5_port_i, ~int4_port_i, int0_en_i};
  assign pin_edge = {1'b1, 1'b1, int0_edge_i};

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    irq_edge_det u_det (
      .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(pin[p]),
      .en_i  (pin_en[p]), .edge_i(pin_edge[p]), .set_o(pin_set[p])
    );
  end

  irq_edge_det u_nmi_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(nmi_i),
    .en_i(1'b1), .edge_i(1'b1), .set_o(nmi_rise)
  );

  assign set = {src_set_i, pin_set};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) nmi_q <= 1'b0;
    else         nmi_q <= nmi_rise | (nmi_q & ~irq_ack_i);

  always_comb begin
    clr = '0;
    if (irq_ack_i && !nmi_q && win_vld) clr[win_idx] = 1'b1;
  end

  irq_src_bank #(.N_SRC(N_SRC_P), .LVL_W(LVL_W_P), .ADDR_W(ADDR_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .set_i     (set),
    .clr_i     (clr),
    .lvl_mode_i(int0_en_i & ~int0_edge_i),
    .lvl_val_i (int0_i),
    .pend_o    (pend),
    .lvl_o     (lvl)
  );

  irq_arbiter #(.N_SRC(N_SRC_P), .LVL_W(LVL_W_P)) u_arb (
    .pend_i(pend), .lvl_i(lvl), .mask_i(cpu_mask_i),
    .vld_o (win_vld), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  assign irq_req_o = nmi_q | win_vld;
  assign irq_nmi_o = nmi_q;
  assign irq_vec_o = nmi_q ? 8'(NMI_VEC) : (win_vld ? vec_of(int'(win_idx)) : 8'h00);
  assign irq_lvl_o = nmi_q ? '1 : win_lvl;

  a_r4_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && !irq_nmi_o) |-> (irq_lvl_o != '0 && irq_lvl_o >= cpu_mask_i));
  a_r3_no_hole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_vec_o != 8'h3C));
  a_r10_nmi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_rise |=> (irq_req_o && irq_nmi_o && irq_vec_o == 8'(NMI_VEC)));

  for (genvar k = 0; k < N_SRC_P; k++) begin : g_chk
    a_r5_best_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_vld && pend[k] && lvl[k] != '0 && lvl[k] >= cpu_mask_i) |->
      (lvl[k] < win_lvl || (lvl[k] == win_lvl && IDX_W'(k) >= win_idx)));
  end
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0; logic [3:0] addr = 0; logic [7:0] wdata = 0, rdata;
  logic [18:0] sset = 0;
  logic i0 = 0, i0_en = 0, i0_edge = 1, i4 = 0, i4_port = 0, i5 = 0, i5_port = 0, nmi = 0;
  logic [2:0] mask = 0; logic ack = 0;
  logic req, is_nmi; logic [7:0] vec; logic [2:0] lvl;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_set_i(sset),
    .int0_i(i0), .int0_en_i(i0_en), .int0_edge_i(i0_edge),
    .int4_i(i4), .int4_port_i(i4_port), .int5_i(i5), .int5_port_i(i5_port),
    .nmi_i(nmi), .cpu_mask_i(mask), .irq_ack_i(ack),
    .irq_req_o(req), .irq_nmi_o(is_nmi), .irq_vec_o(vec), .irq_lvl_o(lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic wr(input int a, input int d);
    we = 1; addr = 4'(a); wdata = 8'(d); tick; we = 0;
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    addr = 4'(a); #1; chk(tag, int'(rdata), exp);
  endtask

  task automatic pulse(input logic [18:0] bits); sset = bits; tick; sset = 0; endtask
  task automatic do_ack; ack = 1; tick; ack = 0; #1; endtask

  task automatic out_chk(input string tag, input int r, input int v, input int l);
    #1; chk({tag, " req"}, int'(req), r);
    if (r != 0) begin
      chk({tag, " vec"}, int'(vec), v);
      chk({tag, " lvl"}, int'(lvl), l);
    end
  endtask

  task automatic t_reset;
    out_chk("R1 reset", 0, 0, 0);
    for (int r = 0; r < 11; r++) rd_chk("R1 reg", r, 0);
  endtask

  task automatic t_write_and_ack;
    wr(5, 8'hFF); rd_chk("R2 write levels only", 5, 8'h77);
    pulse(19'(1) << 8);                 // source 11
    rd_chk("R11 set pulse", 5, 8'hF7);
    out_chk("R3 src11", 1, 8'h58, 7);
    wr(5, 8'h00); rd_chk("R2 pending kept", 5, 8'h80);
    out_chk("R4 level0", 0, 0, 0);
    wr(5, 8'h70); out_chk("R6 level back", 1, 8'h58, 7);
    ack = 1; sset = 19'(1) << 8; tick; ack = 0; sset = 0;
    out_chk("R7 set beats ack", 1, 8'h58, 7);
    do_ack; out_chk("R7 ack clears", 0, 0, 0);
    rd_chk("R7 flag", 5, 8'h70);
  endtask

  task automatic t_mask;
    wr(2, 8'h03); pulse(19'(1) << 1);   // source 4, level 3
    mask = 4; out_chk("R4 below mask", 0, 0, 0);
    mask = 3; out_chk("R4 equal mask", 1, 8'h38, 3);
    wr(2, 8'h00); rd_chk("R4 pending lvl0", 2, 8'h08);
    mask = 0; out_chk("R4 lvl0 ignored", 0, 0, 0);
  endtask

  task automatic t_arb;
    wr(3, 8'h05); wr(4, 8'h50); wr(10, 8'h02);
    pulse((19'(1) << 3) | (19'(1) << 6) | (19'(1) << 17));
    out_chk("R5 tie low index", 1, 8'h44, 5);
    do_ack; out_chk("R5 second", 1, 8'h50, 5);
    do_ack; out_chk("R5 lower level", 1, 8'h7C, 2);
    do_ack; out_chk("R5 drained", 0, 0, 0);
    wr(10, 8'h10); pulse(19'(1) << 18);
    out_chk("R3 last source", 1, 8'h80, 1);
    do_ack; out_chk("R3 cleared", 0, 0, 0);
  endtask

  task automatic t_int0;
    wr(0, 8'h06);
    i0_en = 0; i0_edge = 1; i0 = 1; tick; out_chk("R8 disabled", 0, 0, 0);
    i0_en = 1; tick; out_chk("R8 no edge", 0, 0, 0);
    i0 = 0; tick; i0 = 1; tick; out_chk("R8 edge", 1, 8'h28, 6);
    do_ack; out_chk("R8 ack", 0, 0, 0);
    i0_edge = 0; tick; out_chk("R8 level high", 1, 8'h28, 6);
    i0 = 0; tick; out_chk("R8 level low", 0, 0, 0);
    i0_en = 0; i0_edge = 1;
  endtask

  task automatic t_int45;
    wr(0, 8'h26); wr(1, 8'h02);
    i4_port = 1; i4 = 1; tick; rd_chk("R9 int4 port", 0, 8'h26);
    i4 = 0; i4_port = 0; tick; i4 = 1; tick;
    rd_chk("R9 int4 edge", 0, 8'hA6);
    out_chk("R9 int4 vec", 1, 8'h2C, 2);
    i5_port = 1; i5 = 1; tick; rd_chk("R9 int5 port", 1, 8'h02);
    i5 = 0; i5_port = 0; tick; i5 = 1; tick;
    rd_chk("R9 int5 edge", 1, 8'h0A);
    out_chk("R5 pin tie", 1, 8'h2C, 2);
    do_ack; out_chk("R9 int5 next", 1, 8'h30, 2);
    do_ack; out_chk("R9 drained", 0, 0, 0);
  endtask

  task automatic t_nmi;
    mask = 7; pulse(19'(1) << 8);
    out_chk("R10 before", 1, 8'h58, 7);
    nmi = 1; tick; out_chk("R10 nmi", 1, 8'h20, 7);
    chk("R10 nmi flag", int'(is_nmi), 1);
    do_ack; out_chk("R10 after ack", 1, 8'h58, 7);
    chk("R10 flag off", int'(is_nmi), 0);
    tick; tick; out_chk("R10 held level", 1, 8'h58, 7);
    do_ack; out_chk("R10 drained", 0, 0, 0);
    nmi = 0; mask = 0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    #10 rst_n = 1; tick;
    t_reset;
    t_write_and_ack;
    t_mask;
    t_arb;
    t_int0;
    t_int45;
    t_nmi;
    finish_run;
  end
endmodule